// File: doc/BRIEF.md
# Keyed Software Watchdog

This block is a free-running timeout monitor. Software keeps it quiet by writing a two-byte key to a service register at regular intervals. A down counter measures the time since the last valid service. A small key tracker accepts only the exact ordered pair: an arming byte followed by a firing byte. If the counter runs out while the block is enabled, the block raises a reset request for a fixed number of clocks. It also sets a sticky flag, so that software can later tell that the last reset came from the watchdog.

The enable input freezes the counter without losing its value. Three kinds of reset return the counter and the key tracker to their initial state:

- a synchronous system reset;
- the block's own reset pulse;
- an asynchronous power-on reset.

Only the power-on reset clears the sticky flag. The timeout length, the pulse length, the data width and both key values are parameters.

Top module: `keyed_watchdog`

## Requirements
- R1: While `por_n` is low, and right after it is released, `wd_rst_req` and `wd_rst_flag` are both 0.
- R2: While `wd_enable` is 0 the counter holds its value and `wd_rst_req` never rises. After re-enabling, only the remaining enabled cycles are still needed to reach expiry.
- R3: After reset, with the block enabled and no service, `wd_rst_req` rises at the clock edge that is the TIMEOUT_CYCLES-th enabled edge. The same timeout applies after the end of each reset pulse.
- R4: A write of 0x55 followed by a write of 0xAA restarts the timer. `wd_rst_req` then rises TIMEOUT_CYCLES edges after the edge that captured the 0xAA write, provided there is no further service.
- R5: A write of 0xAA that is not preceded by 0x55 does not change the time of expiry.
- R6: After 0x55, a write of any value other than 0x55 or 0xAA returns the tracker to idle, so a following 0xAA does not restart the timer.
- R7: Repeated writes of 0x55 keep the tracker armed, and a later 0xAA restarts the timer.
- R8: Cycles without a write between 0x55 and 0xAA do not disarm the tracker.
- R9: On expiry, `wd_rst_req` stays high for exactly RST_PULSE_CYCLES clocks. `wd_rst_flag` is 1 from the first of those clocks onward.
- R10: `wd_rst_flag` stays 1 through system resets and later activity, and only `por_n` low clears it.
- R11: A system reset (`sys_rst_n` low at a clock edge) reloads the counter and clears an armed tracker. Expiry then falls TIMEOUT_CYCLES edges after that edge, and a 0xAA written after it does not restart the timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears everything including the flag |
| sys_rst_n | input | 1 | Synchronous system reset, active low; reloads counter and key tracker |
| wd_enable | input | 1 | Watchdog enable; when 0 the counter holds |
| svc_wr | input | 1 | Write strobe for the service register |
| svc_data | input | DATA_W | Byte written to the service register |
| wd_rst_req | output | 1 | Reset request, high for RST_PULSE_CYCLES clocks on expiry |
| wd_rst_flag | output | 1 | Sticky flag: a watchdog expiry has occurred since power-on |

## Verification
The hardest case is telling a real restart apart from a write that is merely ignored. From the ports, both look the same until the counter expires. The stimulus therefore places each key sequence at a known distance after the end of the previous reset pulse. It then predicts the exact edge at which the next reset must rise, once for "restarted" and once for "not restarted". Those two edges always differ, so the exact edge observed shows which case occurred. For the system-reset case, the arming byte is written before the system reset and the firing byte after it. In that way, a tracker that was not cleared and a counter that was not reloaded each give their own wrong edge.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   // Key tracker state: waiting for the arming byte, or armed for the firing byte.
   typedef enum logic {
      KEY_IDLE  = 1'b0,
      KEY_ARMED = 1'b1
   } key_state_e;

endpackage

// File: rtl/wdg_key_tracker.sv
module wdg_key_tracker
   import wdg_pkg::*;
#(
   parameter int unsigned          DATA_W   = 8,
   parameter logic [DATA_W-1:0]    ARM_KEY  = 8'h55,
   parameter logic [DATA_W-1:0]    FIRE_KEY = 8'hAA
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              clear,
   input  logic              wr,
   input  logic [DATA_W-1:0] data,
   output logic              restart
);

   key_state_e state_q;

   generate
      if (ARM_KEY == FIRE_KEY) begin : g_bad_keys
         $error("wdg_key_tracker: arming and firing keys must differ");
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q <= KEY_IDLE;
      end else if (clear) begin
         state_q <= KEY_IDLE;
      end else if (wr) begin
         if (data == ARM_KEY) begin
            state_q <= KEY_ARMED;
         end else begin
            state_q <= KEY_IDLE;
         end
      end
   end

   assign restart = !clear && wr && (state_q == KEY_ARMED) && (data == FIRE_KEY);

   // R6: any write that is not the arming byte leaves the tracker idle
   a_r6_break_disarms: assert property (@(posedge clk) disable iff (!por_n)
      (wr && !clear && data != ARM_KEY) |=> (state_q == KEY_IDLE));

   // R11: a clear always lands in idle, so no restart can follow without re-arming
   a_r11_clear_idle: assert property (@(posedge clk) disable iff (!por_n)
      clear |=> !restart || !(state_q == KEY_ARMED));

endmodule

// File: rtl/wdg_down_counter.sv
module wdg_down_counter #(
   parameter int unsigned TIMEOUT_CYCLES = 1024
) (
   input  logic clk,
   input  logic por_n,
   input  logic clear,
   input  logic enable,
   input  logic restart,
   output logic expire
);

   localparam int unsigned CW = (TIMEOUT_CYCLES < 2) ? 1 : $clog2(TIMEOUT_CYCLES);
   localparam logic [CW-1:0] LOAD = CW'(TIMEOUT_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   generate
      if (TIMEOUT_CYCLES < 2) begin : g_bad_timeout
         $error("wdg_down_counter: TIMEOUT_CYCLES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q <= LOAD;
      end else if (clear || restart) begin
         cnt_q <= LOAD;
      end else if (enable && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire = enable && !clear && !restart && (cnt_q == '0);

   // R4: a completed key sequence reloads the full count
   a_r4_reload: assert property (@(posedge clk) disable iff (!por_n)
      restart |=> (cnt_q == LOAD));

   // R2: with the block disabled and no reload, the count is frozen
   a_r2_hold: assert property (@(posedge clk) disable iff (!por_n)
      (!enable && !clear && !restart) |=> $stable(cnt_q));

   // R3: while enabled and undisturbed, the count never rises
   a_r3_monotonic: assert property (@(posedge clk) disable iff (!por_n)
      (enable && !clear && !restart && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/wdg_reset_pulse.sv
module wdg_reset_pulse #(
   parameter int unsigned RST_PULSE_CYCLES = 16
) (
   input  logic clk,
   input  logic por_n,
   input  logic expire,
   output logic rst_req,
   output logic rst_flag
);

   logic flag_q;

   generate
      if (RST_PULSE_CYCLES < 1) begin : g_bad_pulse
         $error("wdg_reset_pulse: RST_PULSE_CYCLES must be at least 1");
      end else if (RST_PULSE_CYCLES == 1) begin : g_single
         logic req_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               req_q <= 1'b0;
            end else begin
               req_q <= expire;
            end
         end
         assign rst_req = req_q;
      end else begin : g_counted
         localparam int unsigned PW = $clog2(RST_PULSE_CYCLES + 1);
         logic [PW-1:0] left_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               left_q <= '0;
            end else if (left_q != '0) begin
               left_q <= left_q - 1'b1;
            end else if (expire) begin
               left_q <= PW'(RST_PULSE_CYCLES);
            end
         end
         assign rst_req = (left_q != '0);

         // R9: the remaining-length counter never exceeds the pulse length
         a_r9_len_bound: assert property (@(posedge clk) disable iff (!por_n)
            left_q <= PW'(RST_PULSE_CYCLES));
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         flag_q <= 1'b0;
      end else if (expire) begin
         flag_q <= 1'b1;
      end
   end

   assign rst_flag = flag_q;

   // R9: an expiry from the counter starts the pulse on the next edge
   a_r9_expire_pulse: assert property (@(posedge clk) disable iff (!por_n)
      expire |=> rst_req);

   // R9: the flag is set whenever a pulse is running
   a_r9_flag_with_req: assert property (@(posedge clk) disable iff (!por_n)
      rst_req |-> rst_flag);

   // R10: once set, the flag is kept until power-on reset
   a_r10_sticky: assert property (@(posedge clk) disable iff (!por_n)
      rst_flag |=> rst_flag);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
   parameter int unsigned       TIMEOUT_CYCLES   = 1024,
   parameter int unsigned       RST_PULSE_CYCLES = 16,
   parameter int unsigned       DATA_W           = 8,
   parameter logic [DATA_W-1:0] ARM_KEY          = 8'h55,
   parameter logic [DATA_W-1:0] FIRE_KEY         = 8'hAA
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              wd_enable,
   input  logic              svc_wr,
   input  logic [DATA_W-1:0] svc_data,
   output logic              wd_rst_req,
   output logic              wd_rst_flag
);

   logic clear;
   logic restart;
   logic expire;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("keyed_watchdog: DATA_W must be at least 2");
      end
   endgenerate

   // The block's own pulse reinitialises it, as does the system reset.
   assign clear = !sys_rst_n || wd_rst_req;

   wdg_key_tracker #(
      .DATA_W   (DATA_W),
      .ARM_KEY  (ARM_KEY),
      .FIRE_KEY (FIRE_KEY)
   ) i_tracker (
      .clk     (clk),
      .por_n   (por_n),
      .clear   (clear),
      .wr      (svc_wr),
      .data    (svc_data),
      .restart (restart)
   );

   wdg_down_counter #(
      .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
   ) i_counter (
      .clk     (clk),
      .por_n   (por_n),
      .clear   (clear),
      .enable  (wd_enable),
      .restart (restart),
      .expire  (expire)
   );

   wdg_reset_pulse #(
      .RST_PULSE_CYCLES (RST_PULSE_CYCLES)
   ) i_pulse (
      .clk      (clk),
      .por_n    (por_n),
      .expire   (expire),
      .rst_req  (wd_rst_req),
      .rst_flag (wd_rst_flag)
   );

   // R2: a disabled watchdog cannot start a reset pulse
   a_r2_quiet: assert property (@(posedge clk) disable iff (!por_n)
      (!wd_enable && !wd_rst_req) |=> !wd_rst_req);

endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;

   localparam int CLK_PERIOD = 10;
   localparam int T          = 40;
   localparam int P          = 3;
   localparam int WD_LIMIT   = 20000;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       sys_rst_n = 1'b0;
   logic       wd_enable = 1'b0;
   logic       svc_wr = 1'b0;
   logic [7:0] svc_data = 8'h00;
   logic       wd_rst_req;
   logic       wd_rst_flag;

   keyed_watchdog #(
      .TIMEOUT_CYCLES   (T),
      .RST_PULSE_CYCLES (P),
      .DATA_W           (8),
      .ARM_KEY          (8'h55),
      .FIRE_KEY         (8'hAA)
   ) i_keyed_watchdog (
      .clk         (clk),
      .por_n       (por_n),
      .sys_rst_n   (sys_rst_n),
      .wd_enable   (wd_enable),
      .svc_wr      (svc_wr),
      .svc_data    (svc_data),
      .wd_rst_req  (wd_rst_req),
      .wd_rst_flag (wd_rst_flag)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int    n_checks = 0;
   int    n_errors = 0;
   int    exp_edge[$];
   string exp_tag[$];
   int    n_falls = 0;
   int    last_fall = 0;
   int    last_wr = 0;
   bit    done = 1'b0;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   task automatic push(input int e, input string tag);
      exp_edge.push_back(e);
      exp_tag.push_back(tag);
   endtask

   // Monitor: pops the expected rise edge on each pulse and checks its length.
   bit    prev_req = 1'b0;
   int    hi_len = 0;
   int    pe;
   string pt;
   always @(negedge clk) begin
      if (por_n) begin
         if (wd_rst_req && !prev_req) begin
            if (exp_edge.size() == 0) begin
               check(1'b0, "R3", "unexpected reset rise at edge", cyc, -1);
            end else begin
               pe = exp_edge.pop_front();
               pt = exp_tag.pop_front();
               check(cyc == pe, pt, "reset rise edge", cyc, pe);
            end
            check(wd_rst_flag == 1'b1, "R9", "flag at rise", int'(wd_rst_flag), 1);
            hi_len = 1;
         end else if (wd_rst_req) begin
            hi_len++;
         end else if (prev_req) begin
            check(hi_len == P, "R9", "pulse width", hi_len, P);
            last_fall = cyc;
            n_falls++;
         end
      end
      prev_req = wd_rst_req;
   end

   task automatic wait_fall();
      int k = n_falls;
      while (n_falls == k) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      svc_wr = 1'b1;
      svc_data = d;
      last_wr = cyc + 1;
      @(negedge clk);
      svc_wr = 1'b0;
      svc_data = 8'h00;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      check(1'b0, "R3", "watchdog expired at cycle", cyc, WD_LIMIT);
      finish_run();
   end

   initial begin
      int ef;
      int er;
      // R1: reset state
      repeat (3) @(negedge clk);
      check(wd_rst_req == 1'b0, "R1", "req during por", int'(wd_rst_req), 0);
      check(wd_rst_flag == 1'b0, "R1", "flag during por", int'(wd_rst_flag), 0);
      por_n = 1'b1;
      sys_rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(wd_rst_req == 1'b0, "R1", "req after por", int'(wd_rst_req), 0);
      check(wd_rst_flag == 1'b0, "R1", "flag after por", int'(wd_rst_flag), 0);

      // R2: disabled for longer than the timeout
      repeat (100) @(negedge clk);
      check(wd_rst_req == 1'b0, "R2", "req while disabled", int'(wd_rst_req), 0);

      // R3: enable, no service
      @(negedge clk);
      wd_enable = 1'b1;
      push(cyc + T, "R3");
      wait_fall();

      // R4: valid key pair restarts
      repeat (20) @(negedge clk);
      wr(8'h55);
      wr(8'hAA);
      push(last_wr + T, "R4");
      wait_fall();

      // R5: lone firing byte ignored
      ef = last_fall;
      repeat (10) @(negedge clk);
      wr(8'hAA);
      push(ef + T, "R5");
      wait_fall();

      // R6: wrong byte after arming breaks the sequence
      ef = last_fall;
      repeat (5) @(negedge clk);
      wr(8'h55);
      wr(8'h12);
      wr(8'hAA);
      push(ef + T, "R6");
      wait_fall();

      // R7: repeated arming bytes stay armed
      repeat (5) @(negedge clk);
      wr(8'h55);
      wr(8'h55);
      wr(8'h55);
      wr(8'hAA);
      push(last_wr + T, "R7");
      wait_fall();

      // R8: idle gap between the two bytes
      repeat (5) @(negedge clk);
      wr(8'h55);
      repeat (6) @(negedge clk);
      wr(8'hAA);
      push(last_wr + T, "R8");
      wait_fall();

      // R2: hold during a disabled window of 100 edges
      ef = last_fall;
      repeat (10) @(negedge clk);
      wd_enable = 1'b0;
      repeat (100) @(negedge clk);
      check(wd_rst_req == 1'b0, "R2", "req during hold", int'(wd_rst_req), 0);
      wd_enable = 1'b1;
      push(ef + T + 100, "R2");
      wait_fall();

      // R11: system reset between arming and firing bytes
      repeat (5) @(negedge clk);
      wr(8'h55);
      @(negedge clk);
      sys_rst_n = 1'b0;
      er = cyc + 1;
      @(negedge clk);
      sys_rst_n = 1'b1;
      check(wd_rst_flag == 1'b1, "R10", "flag after system reset", int'(wd_rst_flag), 1);
      wr(8'hAA);
      push(er + T, "R11");
      wait_fall();

      // R10: only power-on reset clears the flag
      check(wd_rst_flag == 1'b1, "R10", "flag before por", int'(wd_rst_flag), 1);
      wd_enable = 1'b0;
      @(negedge clk);
      por_n = 1'b0;
      @(negedge clk);
      check(wd_rst_flag == 1'b0, "R10", "flag after por", int'(wd_rst_flag), 0);
      check(wd_rst_req == 1'b0, "R1", "req after second por", int'(wd_rst_req), 0);
      por_n = 1'b1;
      repeat (5) @(negedge clk);

      check(exp_edge.size() == 0, "R3", "pending expected resets", exp_edge.size(), 0);
      finish_run();
   end

endmodule